// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte Lanes

This block is a single-port synchronous static memory built as a two-stage, register-to-register pipeline. Address, control and write data are captured together in one input stage. Writes land in the array on the following clock edge. Reads load an output register on that same following edge. The word is 36 bits wide and split into four 9-bit byte lanes. The array depth is set by an address-width parameter, which is kept small so that simulation stays fast. The shared data bus is modelled as three separate ports: a write-data input, a read-data output and a drive-enable output.

A cycle begins through one of two address strobes. The ungated strobe always starts a cycle. The gated strobe starts a cycle only while the main enable is active. A started cycle checks three chip enables of mixed polarity. If all three are active, the device is selected and the new address is loaded. If any one is inactive, the device is deselected. While the device stays selected, an advance input repeats the access at the held address. Address sequencing for bursts lives in a separate block.

Write enables come in two forms: a global write, and a per-lane write that a lane-group enable qualifies. The output enable is asynchronous and gates the drive flag with no clock involved. When the device is deselected, the output register keeps driving the bus until the read that is already in flight has finished.

Top module: `sync_sram_pipe`

## Requirements
- R1: A cycle starts on a rising clock edge when `strobe_free_n` is low, or when both `strobe_gated_n` and `en_main_n` are low. If `en_main_n` is low, `en_hi` is high and `en_lo_n` is low, the device becomes selected and `addr_i` is loaded as the current address.
- R2: When `en_main_n` is high, `strobe_gated_n` has no effect. With `strobe_free_n` high, such a cycle neither loads an address nor changes the selected state.
- R3: A started cycle in which any of the three chip enables is inactive deselects the device and performs no array access.
- R4: When no cycle starts, `adv_n` is low and the device is selected, the access is repeated at the held address, and the chip enables are not examined. When the device is not selected, `adv_n` is ignored.
- R5: An access with `gw_n` low writes all four lanes from `wdata_i`, whatever the values of `bw_en_n` and `lane_wr_n`. A write cycle turns the drive flag off.
- R6: When `gw_n` is high and `bw_en_n` is low, each low bit k of `lane_wr_n` writes only lane k, which is bits 9k+8 down to 9k. The other lanes keep their contents.
- R7: An access is a read when `gw_n` is high and either `bw_en_n` is high or all four bits of `lane_wr_n` are high.
- R8: For a read sampled on edge E, `rdata_o` shows the word after edge E+1, and the drive flag is set at that same edge. A read issued on the edge right after a write to the same address returns the newly written data.
- R9: `rdata_oe` is high exactly when the internal drive flag is set and `oe_n` is low. A change on `oe_n` takes effect without waiting for a clock edge.
- R10: If a deselect is sampled on edge E, the bus still carries the read sampled on edge E-1 during the cycle after E. `rdata_oe` is low after edge E+1.
- R11: A cycle in which the device is selected but no access occurs (no start, `adv_n` high) leaves both `rdata_o` and the drive flag unchanged.
- R12: Synchronous reset, with `rst` high, deselects the device and clears the drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address |
| en_main_n | input | 1 | Main chip enable, active low; also gates `strobe_gated_n` |
| en_hi | input | 1 | Chip enable, active high |
| en_lo_n | input | 1 | Chip enable, active low |
| strobe_gated_n | input | 1 | Address strobe that is honoured only with the main enable active |
| strobe_free_n | input | 1 | Address strobe that is always honoured |
| adv_n | input | 1 | Repeat the access at the held address, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bw_en_n | input | 1 | Enables the per-lane write bits, active low |
| lane_wr_n | input | LANES | Per-lane write bits, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Bus drive enable for `rdata_o` |

## Verification
Two events can meet in one cycle: a deselect, and the output register delivering the read issued just before it. The bench provokes this with back-to-back reads followed by a failing start, using either the low-active or the high-active enable, or the gated strobe with `en_hi` low. Each cycle's expected drive and data go into a scoreboard, and the scoreboard requires the final read to appear with the drive flag set for exactly one more cycle before the bus goes quiet. A second overlap is a read that follows a lane write to the same address on the next edge. The bench judges it by comparing the merged word against a lane-by-lane model.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

    // Kind of access held in the input stage.
    typedef enum logic [1:0] {
        ACC_DESEL = 2'd0,
        ACC_HOLD  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

    // A cycle starts on the free strobe, or on the gated strobe with main enable low.
    function automatic logic strobe_start(input logic free_n, input logic gated_n,
                                          input logic main_n);
        return !free_n || (!gated_n && !main_n);
    endfunction

    // All three chip enables active.
    function automatic logic enables_ok(input logic main_n, input logic hi,
                                        input logic lo_n);
        return !main_n && hi && !lo_n;
    endfunction

endpackage

// File: rtl/sram_access_decode.sv
module sram_access_decode
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              strobe_gated_n,
    input  logic              strobe_free_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bw_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [DATA_W-1:0] wdata_i,
    output acc_kind_e         s1_kind,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [DATA_W-1:0] s1_wdata,
    output logic [LANES-1:0]  s1_mask
);

    logic              start_c;
    logic              en_ok_c;
    logic              any_lane_c;
    logic [LANES-1:0]  mask_c;
    logic              sel_q;
    logic              sel_c;
    logic [ADDR_W-1:0] addr_c;
    acc_kind_e         kind_c;

    // Per-lane write decode: global write covers every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
        assign mask_c[g] = !gw_n || (!bw_en_n && !lane_wr_n[g]);
    end

    assign any_lane_c = |mask_c;
    assign start_c    = strobe_start(strobe_free_n, strobe_gated_n, en_main_n);
    assign en_ok_c    = enables_ok(en_main_n, en_hi, en_lo_n);

    always_comb begin
        sel_c  = sel_q;
        addr_c = s1_addr;
        kind_c = ACC_DESEL;
        if (start_c) begin
            if (en_ok_c) begin
                sel_c  = 1'b1;
                addr_c = addr_i;
                kind_c = any_lane_c ? ACC_WRITE : ACC_READ;
            end else begin
                sel_c  = 1'b0;
                kind_c = ACC_DESEL;
            end
        end else if (sel_q) begin
            if (!adv_n) begin
                kind_c = any_lane_c ? ACC_WRITE : ACC_READ;
            end else begin
                kind_c = ACC_HOLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            s1_kind  <= ACC_DESEL;
            s1_addr  <= '0;
            s1_wdata <= '0;
            s1_mask  <= '0;
        end else begin
            sel_q    <= sel_c;
            s1_kind  <= kind_c;
            s1_addr  <= addr_c;
            s1_wdata <= wdata_i;
            s1_mask  <= mask_c;
        end
    end

    AST_SEL_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> $past(!en_main_n && en_hi && !en_lo_n)); // R1

    AST_GATED_STROBE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (strobe_free_n && en_main_n) |=> ($stable(sel_q) && $stable(s1_addr))); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (strobe_free_n && (strobe_gated_n || en_main_n)) |=> $stable(s1_addr)); // R4

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         s1_kind,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [DATA_W-1:0] s1_wdata,
    input  logic [LANES-1:0]  s1_mask,
    output logic [DATA_W-1:0] rd_word
);

    logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
    logic [LANES-1:0][LANE_W-1:0] wr_lanes;
    logic [LANES-1:0][LANE_W-1:0] rd_q;

    assign wr_lanes = s1_wdata;
    assign rd_word  = rd_q;

    // Late write: the staged word lands one edge after it was sampled.
    always_ff @(posedge clk) begin
        if (s1_kind == ACC_WRITE) begin
            for (int k = 0; k < LANES; k++) begin
                if (s1_mask[k]) begin
                    mem[s1_addr][k] <= wr_lanes[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (s1_kind == ACC_READ) begin
            rd_q <= mem[s1_addr];
        end
    end

    AST_READ_REG_STILL: assert property (@(posedge clk) disable iff (rst)
        (s1_kind != ACC_READ) |=> $stable(rd_q)); // R11

endmodule

// File: rtl/sram_drive_ctl.sv
module sram_drive_ctl
    import sram_pipe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e s1_kind,
    input  logic      oe_n,
    output logic      rdata_oe
);

    logic drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 1'b0;
        end else begin
            unique case (s1_kind)
                ACC_READ:  drv_q <= 1'b1;
                ACC_WRITE: drv_q <= 1'b0;
                ACC_DESEL: drv_q <= 1'b0;
                ACC_HOLD:  drv_q <= drv_q;
            endcase
        end
    end

    assign rdata_oe = drv_q && !oe_n;

    AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rdata_oe); // R9

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (s1_kind == ACC_WRITE) |=> !drv_q); // R5

    AST_HOLD_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (s1_kind == ACC_HOLD) |=> $stable(drv_q)); // R11

endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              strobe_gated_n,
    input  logic              strobe_free_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bw_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe
);

    acc_kind_e         s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_wdata;
    logic [LANES-1:0]  s1_mask;

    sram_access_decode #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_decode (
        .clk            (clk),
        .rst            (rst),
        .addr_i         (addr_i),
        .en_main_n      (en_main_n),
        .en_hi          (en_hi),
        .en_lo_n        (en_lo_n),
        .strobe_gated_n (strobe_gated_n),
        .strobe_free_n  (strobe_free_n),
        .adv_n          (adv_n),
        .gw_n           (gw_n),
        .bw_en_n        (bw_en_n),
        .lane_wr_n      (lane_wr_n),
        .wdata_i        (wdata_i),
        .s1_kind        (s1_kind),
        .s1_addr        (s1_addr),
        .s1_wdata       (s1_wdata),
        .s1_mask        (s1_mask)
    );

    sram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .s1_kind  (s1_kind),
        .s1_addr  (s1_addr),
        .s1_wdata (s1_wdata),
        .s1_mask  (s1_mask),
        .rd_word  (rdata_o)
    );

    sram_drive_ctl u_drive (
        .clk      (clk),
        .rst      (rst),
        .s1_kind  (s1_kind),
        .oe_n     (oe_n),
        .rdata_oe (rdata_oe)
    );

    // A deselect lets one in-flight read drain, then the bus goes quiet.
    AST_DESEL_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (strobe_start(strobe_free_n, strobe_gated_n, en_main_n) &&
         !enables_ok(en_main_n, en_hi, en_lo_n)) |=> ##1 !rdata_oe); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !rdata_oe); // R12

endmodule

// File: tb/sync_sram_pipe_test.sv
`timescale 1ns/1ps
module sync_sram_pipe_test;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          en_main_n, en_hi, en_lo_n;
    logic          strobe_gated_n, strobe_free_n, adv_n;
    logic          gw_n, bw_en_n;
    logic [LN-1:0] lane_wr_n;
    logic          oe_n;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          rdata_oe;

    always #2.5 clk = ~clk;

    sync_sram_pipe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
        .strobe_gated_n(strobe_gated_n), .strobe_free_n(strobe_free_n),
        .adv_n(adv_n), .gw_n(gw_n), .bw_en_n(bw_en_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe(rdata_oe)
    );

    typedef struct {
        bit            drv;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    exp_t          last_item;
    logic [DW-1:0] model [1 << AW];
    bit            m_sel;
    logic [AW-1:0] m_addr;
    int            checks = 0;
    int            fails  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: the item pushed before edge n is visible after edge n+1.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() >= 2) begin
                exp_t it;
                bit   exp_oe;
                it     = sb_q.pop_front();
                exp_oe = it.drv && !oe_n;
                chk(rdata_oe === exp_oe, it.tag, "drive", DW'(rdata_oe), DW'(exp_oe));
                if (it.drv) chk(rdata_o === it.data, it.tag, "data", rdata_o, it.data);
            end
        end
    end

    // Driver: applies one cycle of inputs and pushes the expected output.
    task automatic step(input bit s_free, input bit s_gated, input bit adv_b,
                        input bit m, input bit h, input bit l,
                        input bit gw, input bit bwe, input bit [LN-1:0] lanes,
                        input bit [AW-1:0] a, input bit [DW-1:0] d,
                        input bit oe, input string tag);
        bit            start, en, acc, hold;
        bit [LN-1:0]   msk;
        exp_t          it;
        strobe_free_n  = s_free;  strobe_gated_n = s_gated; adv_n = adv_b;
        en_main_n      = m;       en_hi = h;                en_lo_n = l;
        gw_n           = gw;      bw_en_n = bwe;            lane_wr_n = lanes;
        addr_i         = a;       wdata_i = d;              oe_n = oe;
        start = !s_free || (!s_gated && !m);
        en    = !m && h && !l;
        acc   = 1'b0;
        hold  = 1'b0;
        if (start) begin
            if (en) begin
                m_sel = 1'b1; m_addr = a; acc = 1'b1;
            end else begin
                m_sel = 1'b0;
            end
        end else if (m_sel) begin
            if (!adv_b) acc = 1'b1;
            else        hold = 1'b1;
        end
        it.drv  = 1'b0;
        it.data = '0;
        it.tag  = tag;
        if (hold) begin
            it     = last_item;
            it.tag = tag;
        end else if (acc) begin
            for (int k = 0; k < LN; k++) msk[k] = !gw || (!bwe && !lanes[k]);
            if (|msk) begin
                for (int k = 0; k < LN; k++)
                    if (msk[k]) model[m_addr][k*LW +: LW] = d[k*LW +: LW];
            end else begin
                it.drv  = 1'b1;
                it.data = model[m_addr];
            end
        end
        last_item = it;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input bit [AW-1:0] a, input bit [DW-1:0] d, input bit gw,
                      input bit bwe, input bit [LN-1:0] lanes, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, gw, bwe, lanes, a, d, 1'b0, tag);
    endtask

    task automatic rd(input bit [AW-1:0] a, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, a, '0, 1'b0, tag);
    endtask

    task automatic idle(input bit oe, input string tag);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hf, '0, '0, oe, tag);
    endtask

    // Advance with the chip enables deliberately inactive: they must not matter.
    task automatic adv_rd(input string tag);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hf, 6'd33, '0, 1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        strobe_free_n = 1'b1; strobe_gated_n = 1'b1; adv_n = 1'b1;
        en_main_n = 1'b1; en_hi = 1'b0; en_lo_n = 1'b1;
        gw_n = 1'b1; bw_en_n = 1'b1; lane_wr_n = 4'hf;
        addr_i = '0; wdata_i = '0; oe_n = 1'b0;
        m_sel = 1'b0; m_addr = '0;
        last_item.drv = 1'b0; last_item.data = '0; last_item.tag = "R12";
        repeat (3) @(negedge clk);
        chk(rdata_oe === 1'b0, "R12", "drive after reset", DW'(rdata_oe), '0);
        rst = 1'b0;

        // Global write ignores lane bits (R5); lane write merges (R6)
        wr(6'd5, 36'h1_2345_6789, 1'b0, 1'b1, 4'hf, "R5");
        wr(6'd6, 36'h9_8765_4321, 1'b0, 1'b0, 4'h0, "R5");
        wr(6'd6, 36'hA_AAAA_AAAA, 1'b1, 1'b0, 4'b0101, "R6");
        // Gated strobe start with main enable low (R1)
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, 6'd5, '0, 1'b0, "R1");
        adv_rd("R4");
        // Read decodes (R7)
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hf, 6'd6, 36'h5, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd5, 36'h5, 1'b0, "R7");
        // Gated strobe with main enable high is ignored (R2), then suspend (R11)
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hf, 6'd7, '0, 1'b0, "R2");
        idle(1'b0, "R11");
        adv_rd("R2");
        // Latency and async output enable (R8, R9)
        rd(6'd6, "R8");
        idle(1'b0, "R11");
        oe_n = 1'b1; #1;
        chk(rdata_oe === 1'b0, "R9", "oe_n high drive", DW'(rdata_oe), '0);
        oe_n = 1'b0; #1;
        chk(rdata_oe === 1'b1, "R9", "oe_n low drive", DW'(rdata_oe), DW'(1));
        chk(rdata_o === model[6], "R8", "held read data", rdata_o, model[6]);
        rd(6'd5, "R9");
        idle(1'b1, "R9");
        idle(1'b0, "R11");
        // Deselect drain with low-active enable off (R3, R10)
        rd(6'd5, "R10");
        rd(6'd6, "R10");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hf, 6'd5, '0, 1'b0, "R3");
        adv_rd("R4");
        idle(1'b0, "R10");
        // Deselect through the gated strobe with high-active enable off (R3)
        rd(6'd6, "R10");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 6'd5, '0, 1'b0, "R3");
        idle(1'b0, "R10");
        idle(1'b0, "R10");
        // Lane write then read on the next edge (R6, R8)
        wr(6'd9, 36'h0_0000_0000, 1'b0, 1'b1, 4'hf, "R5");
        wr(6'd9, 36'h1_FFFF_FFFF, 1'b1, 1'b0, 4'b1110, "R6");
        rd(6'd9, "R6");
        // Write right after a read turns the drive off (R5)
        rd(6'd5, "R8");
        wr(6'd10, 36'h3_3333_3333, 1'b0, 1'b1, 4'hf, "R5");
        rd(6'd10, "R5");
        idle(1'b0, "R11");
        idle(1'b0, "R11");
        idle(1'b0, "R11");
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule